// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Reads

The block is a 16-bit up-counter behind a divide-by-four prescaler on the bus clock. Software reaches it over an 8-bit register bus. The count appears at two high/low byte pairs, a main pair and an alternate pair. Reading a high byte freezes a copy of the low byte, so a high-then-low read returns one coherent 16-bit value even when the count moves between the two accesses.

When the count wraps from 0xFFFF to 0x0000, an overflow flag sets. An interrupt request is raised while that flag and an enable bit are both set. To clear the flag, software reads the status register while the flag is set, then reads the main low byte. Reads of the alternate pair never touch the flag, so a background task can sample the time through the alternate pair without losing an overflow. A write to either low-byte address restarts the counter at 0xFFFC and clears the prescaler.

Top module: `frt_timer`

## Requirements
- R1: The counter advances by exactly one on every fourth bus clock, and holds its value in the other cycles.
- R2: After reset the count is 0xFFFC, the prescaler phase is zero, and the flag, the enable, the arming and the pending read are all clear. The first overflow therefore comes 16 clocks after reset is released.
- R3: The address map is 0 control, 1 status, 2 main high, 3 main low, 4 alternate high and 5 alternate low. The two pairs return the same count.
- R4: A read of either high byte returns the count's upper byte. If no sequence is pending, it copies the current low byte into a buffer and starts a sequence. Further high-byte reads leave the buffer unchanged.
- R5: A read of either low byte returns the buffered byte when a sequence is pending and the live low byte otherwise. Either kind of low-byte read ends the sequence.
- R6: The overflow flag sets on the clock where the count wraps from 0xFFFF to 0x0000. The status register shows it in bit 7, with all other bits reading zero.
- R7: The control register holds the interrupt enable in bit 5, and its other bits read zero. The interrupt request is high exactly while the flag and the enable are both set.
- R8: A status read that sees the flag set arms a clear. The next main low-byte read then clears the flag. Any main low-byte read drops the arming. Reads of the alternate pair, or a main low read without arming, leave the flag set.
- R9: An overflow drops any arming. An overflow on the same clock as a clearing read leaves the flag set.
- R10: A write to either low-byte address reloads 0xFFFC, clears the prescaler and cancels a pending sequence. The flag, the enable and the arming keep their values.
- R11: Writes to the high-byte addresses have no effect. Reads of addresses 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe; read side effects happen on this clock |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data, valid in the cycle the read strobe is high |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A wrong prescaler phase or count value shows up as a wrong byte on the next counter read. It also shifts the overflow, and so the interrupt request, by whole clocks, within at most one 16-clock window after a restart. A stale or wrongly refreshed low-byte buffer is visible only at the next low-byte read after a high-byte read. A wrong arming state is silent until a main low-byte read clears, or fails to clear, the flag. The reference model therefore compares read data and the interrupt line on every clock, so that a divergence is caught on the first cycle it reaches a port.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_MHI  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MLO  = 3'd3;
    localparam logic [ADDR_W-1:0] A_AHI  = 3'd4;
    localparam logic [ADDR_W-1:0] A_ALO  = 3'd5;

    // One-cycle bus operation, decoded from address and strobes
    typedef struct packed {
        logic rd_ctrl;
        logic rd_stat;
        logic rd_hi;
        logic rd_lo_main;
        logic rd_lo_alt;
        logic wr_ctrl;
        logic wr_lo;
    } bus_op_t;

endpackage

// File: rtl/frt_decode.sv
module frt_decode
    import frt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output bus_op_t           op_o
);

    always_comb begin
        op_o            = '0;
        op_o.rd_ctrl    = rd_i && (addr_i == A_CTRL);
        op_o.rd_stat    = rd_i && (addr_i == A_STAT);
        op_o.rd_hi      = rd_i && ((addr_i == A_MHI) || (addr_i == A_AHI));
        op_o.rd_lo_main = rd_i && (addr_i == A_MLO);
        op_o.rd_lo_alt  = rd_i && (addr_i == A_ALO);
        op_o.wr_ctrl    = wr_i && (addr_i == A_CTRL);
        op_o.wr_lo      = wr_i && ((addr_i == A_MLO) || (addr_i == A_ALO));
    end

endmodule

// File: rtl/frt_prescale.sv
module frt_prescale #(
    parameter int unsigned PS_DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);

    localparam int unsigned PS_W = (PS_DIV > 1) ? $clog2(PS_DIV) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PS_DIV - 1);

    generate
        if (PS_DIV <= 1) begin : g_bypass
            logic unused_ps;
            assign unused_ps = clk_i ^ rst_ni ^ clr_i;
            assign tick_o    = 1'b1;
        end else begin : g_div
            logic [PS_W-1:0] ps_d, ps_q;

            always_comb begin
                ps_d = ps_q;
                if (clr_i) begin
                    ps_d = '0;
                end else if (ps_q == PS_LAST) begin
                    ps_d = '0;
                end else begin
                    ps_d = ps_q + PS_W'(1);
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    ps_q <= '0;
                end else begin
                    ps_q <= ps_d;
                end
            end

            assign tick_o = (ps_q == PS_LAST);
        end
    endgenerate

endmodule

// File: rtl/frt_count.sv
module frt_count #(
    parameter int unsigned     CNT_W  = 16,
    parameter logic [CNT_W-1:0] PRESET = 16'hFFFC
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload_i) begin
            cnt_d = PRESET;
        end else if (tick_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= PRESET;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;
    // A restart on the same clock suppresses the wrap
    assign wrap_o  = tick_i && (&cnt_q) && !reload_i;

endmodule

// File: rtl/frt_regs.sv
module frt_regs
    import frt_pkg::*;
#(
    parameter int unsigned BUS_W    = 8,
    parameter int unsigned IE_BIT   = 5,
    parameter int unsigned FLAG_BIT = 7,
    localparam int unsigned CNT_W   = 2 * BUS_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  bus_op_t          op_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             wrap_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic             irq_o,
    output logic             ie_o,
    output logic             flag_o,
    output logic             arm_o,
    output logic             pend_o,
    output logic [BUS_W-1:0] lbuf_o
);

    typedef struct packed {
        logic             ie;
        logic             flag;
        logic             arm;
        logic             pend;
        logic [BUS_W-1:0] lbuf;
    } regs_t;

    regs_t s_d, s_q;

    logic unused_wbits;
    assign unused_wbits = ^wdata_i;

    always_comb begin
        s_d = s_q;

        if (op_i.wr_ctrl) begin
            s_d.ie = wdata_i[IE_BIT];
        end

        // coherent read sequence
        if (op_i.rd_hi && !s_q.pend) begin
            s_d.pend = 1'b1;
            s_d.lbuf = count_i[BUS_W-1:0];
        end
        if (op_i.rd_lo_main || op_i.rd_lo_alt || op_i.wr_lo) begin
            s_d.pend = 1'b0;
        end

        // two-step flag clear
        if (op_i.rd_stat && s_q.flag) begin
            s_d.arm = 1'b1;
        end
        if (op_i.rd_lo_main) begin
            if (s_q.arm && s_q.flag) begin
                s_d.flag = 1'b0;
            end
            s_d.arm = 1'b0;
        end

        // a fresh overflow wins over clearing and voids the arming
        if (wrap_i) begin
            s_d.flag = 1'b1;
            s_d.arm  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (op_i.rd_ctrl) begin
            rdata_o[IE_BIT] = s_q.ie;
        end
        if (op_i.rd_stat) begin
            rdata_o[FLAG_BIT] = s_q.flag;
        end
        if (op_i.rd_hi) begin
            rdata_o = count_i[CNT_W-1:BUS_W];
        end
        if (op_i.rd_lo_main || op_i.rd_lo_alt) begin
            rdata_o = s_q.pend ? s_q.lbuf : count_i[BUS_W-1:0];
        end
    end

    assign irq_o  = s_q.flag & s_q.ie;
    assign ie_o   = s_q.ie;
    assign flag_o = s_q.flag;
    assign arm_o  = s_q.arm;
    assign pend_o = s_q.pend;
    assign lbuf_o = s_q.lbuf;

endmodule

// File: rtl/frt_timer.sv
module frt_timer
    import frt_pkg::*;
#(
    parameter int unsigned BUS_W    = 8,
    parameter int unsigned PS_DIV   = 4,
    parameter int unsigned IE_BIT   = 5,
    parameter int unsigned FLAG_BIT = 7,
    parameter logic [2*BUS_W-1:0] PRESET = 16'hFFFC
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              irq_o
);

    localparam int unsigned CNT_W = 2 * BUS_W;

    bus_op_t          op;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] count;
    logic             ie_q, flag_q, arm_q, pend_q;
    logic [BUS_W-1:0] lbuf_q;

    frt_decode u_decode (
        .addr_i (addr_i),
        .rd_i   (rd_i),
        .wr_i   (wr_i),
        .op_o   (op)
    );

    frt_prescale #(
        .PS_DIV (PS_DIV)
    ) u_prescale (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (op.wr_lo),
        .tick_o (tick)
    );

    frt_count #(
        .CNT_W  (CNT_W),
        .PRESET (PRESET)
    ) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .reload_i (op.wr_lo),
        .count_o  (count),
        .wrap_o   (wrap)
    );

    frt_regs #(
        .BUS_W    (BUS_W),
        .IE_BIT   (IE_BIT),
        .FLAG_BIT (FLAG_BIT)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .op_i    (op),
        .wdata_i (wdata_i),
        .count_i (count),
        .wrap_i  (wrap),
        .rdata_o (rdata_o),
        .irq_o   (irq_o),
        .ie_o    (ie_q),
        .flag_o  (flag_q),
        .arm_o   (arm_q),
        .pend_o  (pend_q),
        .lbuf_o  (lbuf_q)
    );

endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
    parameter int unsigned      CNT_W  = 16,
    parameter int unsigned      BUS_W  = 8,
    parameter logic [CNT_W-1:0] PRESET = 16'hFFFC
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick,
    input logic             reload,
    input logic             wrap,
    input logic             rd_hi,
    input logic             rd_lo_main,
    input logic [CNT_W-1:0] count,
    input logic             flag,
    input logic             arm,
    input logic             pend,
    input logic [BUS_W-1:0] lbuf
);

    // R1
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && !reload) |=> (count == $past(count) + CNT_W'(1)));

    // R1
    count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick && !reload) |=> $stable(count));

    // R10
    restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload |=> ((count == PRESET) && !pend));

    // R6
    wrap_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> flag);

    // R9
    wrap_drops_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> !arm);

    // R8
    clear_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag) |-> ($past(arm) && $past(rd_lo_main)));

    // R4
    buffer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_hi && pend) |=> $stable(lbuf));

endmodule

bind frt_timer frt_checker #(
    .CNT_W  (2 * BUS_W),
    .BUS_W  (BUS_W),
    .PRESET (PRESET)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick       (tick),
    .reload     (op.wr_lo),
    .wrap       (wrap),
    .rd_hi      (op.rd_hi),
    .rd_lo_main (op.rd_lo_main),
    .count      (count),
    .flag       (flag_q),
    .arm        (arm_q),
    .pend       (pend_q),
    .lbuf       (lbuf_q)
);

// File: tb/sim_frt_timer.sv
module sim_frt_timer;
    import frt_pkg::*;

    logic              clk    = 1'b0;
    logic              rst_ni = 1'b0;
    logic              rd     = 1'b0;
    logic              wr     = 1'b0;
    logic [ADDR_W-1:0] addr   = '0;
    logic [7:0]        wdata  = '0;
    logic [7:0]        rdata;
    logic              irq;

    always #10 clk = ~clk;

    frt_timer u0 (
        .clk_i   (clk),
        .rst_ni  (rst_ni),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rd_i    (rd),
        .wr_i    (wr),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural reference state
    int m_cnt, m_ps, m_flag, m_arm, m_ie, m_pend, m_buf;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_read(int a);
        case (a)
            0:       return m_ie << 5;
            1:       return m_flag << 7;
            2, 4:    return (m_cnt >> 8) & 255;
            3, 5:    return m_pend ? m_buf : (m_cnt & 255);
            default: return 0;
        endcase
    endfunction

    function automatic string deftag(int a);
        case (a)
            0:       return "R7";
            1:       return "R6";
            2, 4:    return "R4";
            3, 5:    return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic m_step(bit r, bit w, int a, int d);
        int tick, lo_w, wrapv;
        int n_cnt, n_ps, n_pend, n_buf, n_flag, n_arm, n_ie;
        tick  = (m_ps == 3);
        lo_w  = w && (a == 3 || a == 5);
        wrapv = tick && (m_cnt == 16'hFFFF) && !lo_w;
        if (lo_w) begin
            n_cnt = 16'hFFFC;
            n_ps  = 0;
        end else begin
            n_ps  = (m_ps + 1) % 4;
            n_cnt = tick ? ((m_cnt + 1) & 16'hFFFF) : m_cnt;
        end
        n_pend = m_pend;
        n_buf  = m_buf;
        if (r && (a == 2 || a == 4) && !m_pend) begin
            n_pend = 1;
            n_buf  = m_cnt & 255;
        end
        if (r && (a == 3 || a == 5)) n_pend = 0;
        if (lo_w) n_pend = 0;
        n_flag = m_flag;
        n_arm  = m_arm;
        if (r && a == 1 && m_flag) n_arm = 1;
        if (r && a == 3) begin
            if (m_arm && m_flag) n_flag = 0;
            n_arm = 0;
        end
        if (wrapv) begin
            n_flag = 1;
            n_arm  = 0;
        end
        n_ie = (w && a == 0) ? ((d >> 5) & 1) : m_ie;
        m_cnt = n_cnt; m_ps = n_ps; m_pend = n_pend; m_buf = n_buf;
        m_flag = n_flag; m_arm = n_arm; m_ie = n_ie;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic cyc(bit r, bit w, int a, int d, string tag);
        rd    = r;
        wr    = w;
        addr  = a[ADDR_W-1:0];
        wdata = d[7:0];
        #1;
        if (r) chk((tag == "") ? deftag(a) : tag, 16'(rdata), 16'(m_read(a)));
        chk("R7", 16'(irq), 16'(m_flag & m_ie));
        @(posedge clk);
        m_step(r, w, a, d);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, "");
    endtask

    task automatic rdr(int a, string tag);
        cyc(1, 0, a, 0, tag);
    endtask

    task automatic wrr(int a, int d);
        cyc(0, 1, a, d, "");
    endtask

    initial begin
        m_cnt = 16'hFFFC; m_ps = 0; m_flag = 0; m_arm = 0;
        m_ie = 0; m_pend = 0; m_buf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;

        // R2: reset state of every readable register
        rdr(0, "R2");
        rdr(1, "R2");
        rdr(2, "R2");
        rdr(3, "R2");
        // R7: enable the interrupt
        wrr(0, 8'h20);
        rdr(0, "R7");
        // R2 and R6: poll status across the first overflow
        for (int i = 0; i < 14; i++) rdr(1, "R2");

        // R8: alternate reads do not clear, the armed main read does
        rdr(1, "R8");
        rdr(5, "R8");
        rdr(4, "R8");
        rdr(5, "R8");
        rdr(1, "R8");
        rdr(3, "R8");
        rdr(1, "R8");

        // R1: count progression seen through the main pair
        for (int i = 0; i < 6; i++) begin
            rdr(3, "R1");
            idle(i + 1);
        end

        // R10: restart through the alternate low byte, overflow follows
        wrr(5, 8'hA5);
        rdr(2, "R10");
        rdr(3, "R10");
        idle(20);
        // R8: main low read without arming keeps the flag
        rdr(3, "R8");
        rdr(1, "R8");
        // R9: arming voided by a fresh overflow after a restart
        wrr(3, 8'h00);
        rdr(1, "R10");
        idle(20);
        rdr(3, "R9");
        rdr(1, "R9");
        rdr(1, "R8");
        rdr(3, "R8");
        rdr(1, "R8");

        // R4/R5: coherent read with repeated high reads
        idle(37);
        rdr(2, "R4");
        idle(9);
        rdr(2, "R4");
        idle(5);
        rdr(3, "R5");
        rdr(3, "R5");
        // R3: alternate pair against the main pair
        rdr(4, "R3");
        idle(7);
        rdr(5, "R3");
        rdr(2, "R3");
        rdr(4, "R3");
        rdr(5, "R3");
        rdr(3, "R3");

        // R10: a restart ends a pending sequence
        rdr(4, "R10");
        wrr(5, 8'hFF);
        idle(3);
        rdr(3, "R10");

        // R11: high-byte writes ignored, unused addresses read zero
        wrr(2, 8'h12);
        wrr(4, 8'h34);
        rdr(2, "R11");
        rdr(3, "R11");
        rdr(6, "R11");
        rdr(7, "R11");

        // R7: disable via a write with every other bit set
        wrr(0, 8'hDF);
        rdr(0, "R7");
        idle(30);
        rdr(1, "R7");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule